// File: doc/BRIEF.md
# Four-Round ARX Box

This block is a keyed add-rotate-xor mixer for one 64-bit branch of a wide permutation. It takes two 32-bit words, x and y, plus a 32-bit constant c, and applies four rounds of modular addition, right rotation and XOR. Each round uses its own pair of rotation amounts, and the same constant is folded into x at the close of every round. The surrounding logic picks the constant and combines the result with other branches.

In the default form the block accepts an operand set through a valid/ready handshake and captures it. It then runs one round per clock, raises `out_valid` four cycles after the accepting edge, and holds the result until the next operand set is accepted. A parameter selects a purely combinational form with the same ports, which suits a fully unrolled permutation. In that form the result follows the inputs in the same cycle.

Top module: `arx_box`

## Requirements
- R1: A round computes, in this order: x = x + ROR(y, a) modulo 2^32, then y = y ^ ROR(x, b) using the new x, then x = x ^ c. ROR is a rotation to the right.
- R2: The rotation pairs (a, b) for the four rounds are, in order: (31, 24), (17, 17), (0, 31), (24, 16). A 2-bit round counter steps through them, advancing by one each busy cycle.
- R3: The same constant c is applied in all four rounds of one operation.
- R4: An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the four cycles in which rounds are being computed.
- R5: `out_valid` rises on the fourth rising edge after the accepting edge, and `x_out` and `y_out` then carry the four-round result.
- R6: Once `out_valid` is high, it stays high and `x_out` and `y_out` stay unchanged until another operation is accepted.
- R7: x, y and c are captured on the accepting edge. Changes to `x_in`, `y_in` and `c_in` after that edge do not alter the result.
- R8: A new operation may be accepted in the first cycle in which a result is shown. That accepting edge drops `out_valid`, and the new result appears four edges later.
- R9: Synchronous active-high reset leaves `out_valid` at 0, `in_ready` at 1 and both output words at 0.
- R10: With COMBINATIONAL set to 1, `x_out` and `y_out` equal the four-round result of the present inputs in the same cycle, `in_ready` is held at 1, and `out_valid` follows `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can accept an operand set |
| x_in | input | 32 | First word of the branch |
| y_in | input | 32 | Second word of the branch |
| c_in | input | 32 | Round constant |
| out_valid | output | 1 | Result present on x_out and y_out |
| x_out | output | 32 | First result word |
| y_out | output | 32 | Second result word |

## Verification
Delivering a finished result and accepting the next operand set can happen on the same edge. This occurs when a new operation is offered in the first cycle in which `out_valid` is high. The bench drives several operations back to back with `in_valid` held high while the block is busy, so each one is accepted at the earliest edge `in_ready` allows. A scoreboard then confirms three things: `out_valid` drops on that edge, the next result rises exactly four edges later, and it matches an independent model computed from the captured operands, not from the inputs that are scrambled afterwards.

// File: rtl/arx_box_pkg.sv
`timescale 1ns/1ps
package arx_box_pkg;

    parameter int WORD_W   = 32;
    parameter int N_ROUNDS = 4;
    localparam int RIDX_W  = $clog2(N_ROUNDS);
    localparam int ROT_W   = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROT_W-1:0]  rot_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef struct packed {
        word_t x;
        word_t y;
    } pair_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // right rotation; a zero amount leaves the word unchanged
    function automatic word_t rotr(word_t v, rot_t s);
        return (v >> s) | (v << ((ROT_W+1)'(WORD_W) - {1'b0, s}));
    endfunction

    // rotation applied to y before the addition into x
    function automatic rot_t rot_add(ridx_t r);
        case (r)
            2'd0:    return rot_t'(31);
            2'd1:    return rot_t'(17);
            2'd2:    return rot_t'(0);
            default: return rot_t'(24);
        endcase
    endfunction

    // rotation applied to the new x before the XOR into y
    function automatic rot_t rot_mix(ridx_t r);
        case (r)
            2'd0:    return rot_t'(24);
            2'd1:    return rot_t'(17);
            2'd2:    return rot_t'(31);
            default: return rot_t'(16);
        endcase
    endfunction

endpackage

// File: rtl/arx_round.sv
`timescale 1ns/1ps
module arx_round
    import arx_box_pkg::*;
(
    input  pair_t p_in,
    input  word_t k,
    input  ridx_t idx,
    output pair_t p_out
);
    word_t sum_x;
    word_t mix_y;

    always_comb begin
        sum_x     = p_in.x + rotr(p_in.y, rot_add(idx));
        mix_y     = p_in.y ^ rotr(sum_x, rot_mix(idx));
        p_out.x   = sum_x ^ k;
        p_out.y   = mix_y;
    end
endmodule

// File: rtl/arx_round_ctrl.sv
`timescale 1ns/1ps
module arx_round_ctrl
    import arx_box_pkg::*;
#(
    parameter int ROUNDS = N_ROUNDS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_req,
    output logic  ready,
    output logic  load,
    output logic  busy,
    output logic  done,
    output ridx_t round_idx
);
    localparam ridx_t LAST = ridx_t'(ROUNDS - 1);

    seq_state_e state_q;
    ridx_t      cnt_q;

    assign ready     = (state_q != ST_BUSY);
    assign load      = start_req && ready;
    assign busy      = (state_q == ST_BUSY);
    assign done      = (state_q == ST_DONE);
    assign round_idx = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= ST_BUSY;
            cnt_q   <= '0;
        end else if (state_q == ST_BUSY) begin
            if (cnt_q == LAST) begin
                state_q <= ST_DONE;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    p_accept_starts_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> busy && !ready && round_idx == '0);

    p_round_step_r2: assert property (@(posedge clk) disable iff (rst)
        busy && round_idx != LAST |=> busy && round_idx == $past(round_idx) + 1'b1);

    p_last_round_done_r5: assert property (@(posedge clk) disable iff (rst)
        busy && round_idx == LAST |=> done && ready);

    p_done_stays_r6: assert property (@(posedge clk) disable iff (rst)
        done && !start_req |=> done);
endmodule

// File: rtl/arx_box.sv
`timescale 1ns/1ps
module arx_box
    import arx_box_pkg::*;
#(
    parameter bit COMBINATIONAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] x_in,
    input  logic [WORD_W-1:0] y_in,
    input  logic [WORD_W-1:0] c_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] x_out,
    output logic [WORD_W-1:0] y_out
);
    generate
        if (COMBINATIONAL) begin : g_unrolled
            pair_t chain [N_ROUNDS+1];

            assign chain[0] = '{x: x_in, y: y_in};
            for (genvar g = 0; g < N_ROUNDS; g++) begin : g_stage
                arx_round u_round (
                    .p_in  (chain[g]),
                    .k     (c_in),
                    .idx   (ridx_t'(g)),
                    .p_out (chain[g+1])
                );
            end
            assign x_out     = chain[N_ROUNDS].x;
            assign y_out     = chain[N_ROUNDS].y;
            assign in_ready  = 1'b1;
            assign out_valid = in_valid;
        end else begin : g_iterative
            pair_t st_q;
            pair_t st_nxt;
            word_t key_q;
            logic  load, busy, done, ready;
            ridx_t ridx;

            arx_round_ctrl #(.ROUNDS(N_ROUNDS)) u_ctrl (
                .clk       (clk),
                .rst       (rst),
                .start_req (in_valid),
                .ready     (ready),
                .load      (load),
                .busy      (busy),
                .done      (done),
                .round_idx (ridx)
            );

            arx_round u_round (
                .p_in  (st_q),
                .k     (key_q),
                .idx   (ridx),
                .p_out (st_nxt)
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q  <= '0;
                    key_q <= '0;
                end else if (load) begin
                    st_q  <= '{x: x_in, y: y_in};
                    key_q <= c_in;
                end else if (busy) begin
                    st_q  <= st_nxt;
                end
            end

            assign x_out     = st_q.x;
            assign y_out     = st_q.y;
            assign in_ready  = ready;
            assign out_valid = done;

            p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
                out_valid && !in_valid |=> out_valid && $stable(x_out) && $stable(y_out));

            p_start_drops_valid_r8: assert property (@(posedge clk) disable iff (rst)
                in_valid && in_ready |=> !out_valid && !in_ready);

            p_key_frozen_r7: assert property (@(posedge clk) disable iff (rst)
                busy && !$past(load) |-> $stable(key_q));
        end
    endgenerate
endmodule

// File: tb/test_arx_box.sv
`timescale 1ns/1ps
module test_arx_box;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] x_in = '0, y_in = '0, c_in = '0;
    logic        out_valid;
    logic [31:0] x_out, y_out;

    logic        cv = 1'b0;
    logic        c_ready;
    logic [31:0] cx = '0, cy = '0, cc = '0;
    logic        c_valid;
    logic [31:0] cx_out, cy_out;

    int n_checks = 0;
    int n_fail   = 0;
    int n_push   = 0;
    int n_pop    = 0;
    bit ended    = 1'b0;

    logic [63:0] exp_q [$];

    always #4 clk = ~clk;

    arx_box #(.COMBINATIONAL(1'b0)) i_arx_box (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .x_in(x_in), .y_in(y_in), .c_in(c_in),
        .out_valid(out_valid), .x_out(x_out), .y_out(y_out)
    );

    arx_box #(.COMBINATIONAL(1'b1)) i_arx_box_comb (
        .clk(clk), .rst(rst), .in_valid(cv), .in_ready(c_ready),
        .x_in(cx), .y_in(cy), .c_in(cc),
        .out_valid(c_valid), .x_out(cx_out), .y_out(cy_out)
    );

    function automatic logic [31:0] ror32(logic [31:0] v, int s);
        logic [63:0] t;
        t = {v, v} >> s;
        return t[31:0];
    endfunction

    function automatic logic [63:0] model(logic [31:0] x, logic [31:0] y, logic [31:0] c);
        int ra [4] = '{31, 17, 0, 24};
        int rb [4] = '{24, 17, 31, 16};
        for (int r = 0; r < 4; r++) begin
            x = x + ror32(y, ra[r]);
            y = y ^ ror32(x, rb[r]);
            x = x ^ c;
        end
        return {x, y};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // driver: offers an operand set, holds it until accepted, then optionally scrambles inputs
    task automatic send(logic [31:0] x, logic [31:0] y, logic [31:0] c, bit scramble);
        bit acc;
        @(posedge clk); #2;
        in_valid = 1'b1; x_in = x; y_in = y; c_in = c;
        exp_q.push_back(model(x, y, c));
        n_push++;
        do begin
            acc = in_ready;
            @(posedge clk);
        end while (!acc);
        #2;
        in_valid = 1'b0;
        if (scramble) begin
            x_in = $urandom(); y_in = $urandom(); c_in = $urandom();
        end
    endtask

    // monitor / scoreboard
    int          age = 99;
    logic        prev_valid = 1'b0;
    logic [63:0] prev_out = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && !prev_valid) begin
                check(age == 4, "R5 latency", 64'(age), 64'd4);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 R2 R3 unexpected result", {x_out, y_out}, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    n_pop++;
                    check({x_out, y_out} == e, "R1 R2 R3 result", {x_out, y_out}, e);
                end
            end
            if (out_valid && prev_valid)
                check({x_out, y_out} == prev_out, "R6 hold", {x_out, y_out}, prev_out);
            if (age <= 3) begin
                check(in_ready == 1'b0, "R4 ready low while busy", 64'(in_ready), 64'd0);
                check(out_valid == 1'b0, "R8 valid low after accept", 64'(out_valid), 64'd0);
            end
            if (in_valid && in_ready) age = 0;
            else if (age < 99) age++;
            prev_valid = out_valid;
            prev_out   = {x_out, y_out};
        end
    end

    initial begin
        #1_600_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        x_in = 32'hdead_beef; y_in = 32'h1234_5678; c_in = 32'hffff_0000;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R9 reset flags",
              {62'd0, out_valid, in_ready}, 64'd1);
        check({x_out, y_out} == 64'd0, "R9 reset words", {x_out, y_out}, 64'd0);
        @(posedge clk); #2;
        rst = 1'b0;

        send(32'h0, 32'h0, 32'h0, 1'b0);
        repeat (8) @(posedge clk);
        send(32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 1'b1);
        repeat (5) @(posedge clk);
        send(32'h0, 32'h0, 32'hb7e1_5162, 1'b1);
        repeat (6) @(posedge clk);
        // R7: inputs scrambled right after capture; R8: back-to-back accepts
        for (int i = 0; i < 12; i++)
            send($urandom(), $urandom(), $urandom(), 1'b1);
        repeat (7) @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            send($urandom(), $urandom(), $urandom(), 1'b1);
            repeat (i) @(posedge clk);
        end
        repeat (10) @(posedge clk);
        check(exp_q.size() == 0 && n_pop == n_push, "R5 all results delivered",
              64'(n_pop), 64'(n_push));

        // R10: combinational variant
        for (int i = 0; i < 10; i++) begin
            logic [63:0] e;
            @(negedge clk);
            cx = (i == 0) ? 32'h0 : (i == 1) ? 32'hffff_ffff : $urandom();
            cy = (i == 0) ? 32'h0 : (i == 1) ? 32'hffff_ffff : $urandom();
            cc = (i == 0) ? 32'h0 : (i == 1) ? 32'hffff_ffff : $urandom();
            cv = i[0];
            #1;
            e = model(cx, cy, cc);
            check({cx_out, cy_out} == e, "R10 comb result", {cx_out, cy_out}, e);
            check(c_ready == 1'b1 && c_valid == cv, "R10 comb handshake",
                  {62'd0, c_ready, c_valid}, {62'd0, 1'b1, cv});
        end
        report();
    end
endmodule